// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with BCD Correction

This block is the byte-wide data path behind a small controller's accumulator. It takes the accumulator value, a second operand byte, the carry and auxiliary-carry flags and a four-bit operation code. It returns the new accumulator value, the new flags and a write-back value for the operand. Binary addition, bitwise logic, increment, decrement, clearing, complementing, rotates with and without carry, nibble swap, low-digit exchange and decimal adjust after a BCD addition are all handled in one unit.

The logic is purely combinational. The parameter `REG_OUT` chooses whether the outputs come straight from that logic (0) or through one register stage (1, the default). Fetching operands and writing back to a register file are left to the surrounding core.

Top module: `acc_alu`

## Requirements
- R1: With `REG_OUT`=1, a clock edge while `rst_n` is low clears `res_o`, `opnd_o`, `cy_o` and `ac_o` to 0.
- R2: Code 0 (add) gives `acc_i + opnd_i` modulo 256. Code 1 (add with carry) gives `acc_i + opnd_i + cy_i`. In both, `cy_o` is 1 when the full sum exceeds 255, including the case where only adding the carry-in overflows.
- R3: For codes 0 and 1, `ac_o` is 1 when the low-nibble sum plus the carry-in (`cy_i` for code 1, 0 for code 0) exceeds 15.
- R4: Code 14 (decimal adjust) first adds 6 when `ac_i` is 1 or the low nibble of `acc_i` is above 9. A carry out of this step is ORed into the carry.
- R5: Code 14 then adds 0x60 when the carry from R4 is 1 or the intermediate byte is above 0x99. `cy_o` is the OR of `cy_i`, the R4 carry and this step's overflow, so it is never cleared. `ac_o` keeps `ac_i`.
- R6: Code 10 (rotate left through carry) sends bit 7 to `cy_o` and `cy_i` to bit 0. Code 12 (rotate right through carry) sends bit 0 to `cy_o` and `cy_i` to bit 7. `ac_o` keeps `ac_i`.
- R7: Code 9 rotates left by one and code 11 rotates right by one, each within the 8 bits. Code 13 exchanges the two nibbles. All three keep both flags.
- R8: Code 15 (digit exchange) puts `opnd_i[3:0]` into `res_o[3:0]` and `acc_i[3:0]` into `opnd_o[3:0]`. The upper nibbles of both stay as they were, and the flags are held.
- R9: Codes 2 (AND), 3 (OR), 4 (XOR), 5 (increment), 6 (decrement), 7 (clear) and 8 (complement) give the expected byte, wrapping modulo 256, and keep both flags.
- R10: For every code except 15, `opnd_o` equals `opnd_i`.
- R11: With `REG_OUT`=1, the outputs show the result of the inputs present at the previous rising edge, exactly one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand byte |
| cy_i | input | 1 | Carry flag in |
| ac_i | input | 1 | Auxiliary-carry flag in |
| res_o | output | 8 | New accumulator value |
| opnd_o | output | 8 | Operand write-back value |
| cy_o | output | 1 | Carry flag out |
| ac_o | output | 1 | Auxiliary-carry flag out |

## Verification
The bench targets the add-with-carry case where only the carry-in overflows. A design that took carry from the operand sum alone would drop that carry. It also targets the auxiliary carry produced only by the carry-in, which a rule ignoring the carry-in would miss.

For decimal adjust, the bench covers a case where the +6 step itself overflows (0xFB) and a case where the carry arrives already set with a small value. A non-sticky or single-stage correction would produce a wrong high digit or clear the carry there.

The bench also checks that rotates, logic operations and increments keep both flags, and that digit exchange leaves both upper nibbles alone. A shared flag path that leaked would corrupt the flags, and a full-byte swap would corrupt the upper nibbles.

// File: rtl/acc_alu_pkg.sv
// Shared widths and operation codes for the accumulator ALU.
package acc_alu_pkg;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,  OP_ADDC = 4'd1,  OP_AND  = 4'd2,  OP_OR   = 4'd3,
        OP_XOR  = 4'd4,  OP_INC  = 4'd5,  OP_DEC  = 4'd6,  OP_CLR  = 4'd7,
        OP_CPL  = 4'd8,  OP_RL   = 4'd9,  OP_RLC  = 4'd10, OP_RR   = 4'd11,
        OP_RRC  = 4'd12, OP_SWAP = 4'd13, OP_DA   = 4'd14, OP_XCHD = 4'd15
    } alu_op_e;
endpackage

// File: rtl/acc_alu_arith.sv
// Binary adder with nibble carry, plus the two-stage BCD correction.
// Assumes byte-wide data; the decimal constants only make sense for 8 bits.
module acc_alu_arith
    import acc_alu_pkg::*;
(
    input  logic [BYTE_W-1:0] a,
    input  logic [BYTE_W-1:0] b,
    input  logic              add_cin,
    input  logic              cy_in,
    input  logic              ac_in,
    output logic [BYTE_W-1:0] sum,
    output logic              sum_cy,
    output logic              sum_ac,
    output logic [BYTE_W-1:0] da_res,
    output logic              da_cy
);
    logic [BYTE_W:0]   sum_w;
    logic [NIB_W:0]    half_w;
    logic              lo_fix, hi_fix, step1_cy;
    logic [BYTE_W:0]   step1, step2;
    logic [BYTE_W-1:0] lo_add, hi_add;

    // Binary sum with carry-in and nibble carry
    always_comb begin
        sum_w  = {1'b0, a} + {1'b0, b} + {{BYTE_W{1'b0}}, add_cin};
        half_w = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, add_cin};
        sum    = sum_w[BYTE_W-1:0];
        sum_cy = sum_w[BYTE_W];
        sum_ac = half_w[NIB_W];
    end

    // Decimal correction: low digit first, then high digit with sticky carry
    always_comb begin
        lo_fix   = ac_in || (a[NIB_W-1:0] > 4'd9);
        lo_add   = lo_fix ? 8'h06 : 8'h00;
        step1    = {1'b0, a} + {1'b0, lo_add};
        step1_cy = cy_in || step1[BYTE_W];
        hi_fix   = step1_cy || (step1[BYTE_W-1:0] > 8'h99);
        hi_add   = hi_fix ? 8'h60 : 8'h00;
        step2    = {1'b0, step1[BYTE_W-1:0]} + {1'b0, hi_add};
        da_res   = step2[BYTE_W-1:0];
        da_cy    = step1_cy || step2[BYTE_W];
    end
endmodule

// File: rtl/acc_alu_shift.sv
// Rotates, nibble swap and low-digit exchange. Pure wiring, no flags kept here.
module acc_alu_shift
    import acc_alu_pkg::*;
(
    input  logic [BYTE_W-1:0] a,
    input  logic [BYTE_W-1:0] b,
    input  logic              cin,
    output logic [BYTE_W-1:0] rl,
    output logic [BYTE_W-1:0] rlc,
    output logic              rlc_cy,
    output logic [BYTE_W-1:0] rr,
    output logic [BYTE_W-1:0] rrc,
    output logic              rrc_cy,
    output logic [BYTE_W-1:0] swap,
    output logic [BYTE_W-1:0] xchd_a,
    output logic [BYTE_W-1:0] xchd_b
);
    // Bit moves for every rotate-style operation
    always_comb begin
        rl     = {a[BYTE_W-2:0], a[BYTE_W-1]};
        rlc    = {a[BYTE_W-2:0], cin};
        rlc_cy = a[BYTE_W-1];
        rr     = {a[0], a[BYTE_W-1:1]};
        rrc    = {cin, a[BYTE_W-1:1]};
        rrc_cy = a[0];
        swap   = {a[NIB_W-1:0], a[BYTE_W-1:NIB_W]};
        xchd_a = {a[BYTE_W-1:NIB_W], b[NIB_W-1:0]};
        xchd_b = {b[BYTE_W-1:NIB_W], a[NIB_W-1:0]};
    end
endmodule

// File: rtl/acc_alu_logic.sv
// Bitwise operations, increment, decrement, clear and complement.
// Codes outside its set return the accumulator; the top never selects them.
module acc_alu_logic
    import acc_alu_pkg::*;
(
    input  alu_op_e           op,
    input  logic [BYTE_W-1:0] a,
    input  logic [BYTE_W-1:0] b,
    output logic [BYTE_W-1:0] res
);
    // Select the logic result for the requested code
    always_comb begin
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_INC:  res = a + 8'd1;
            OP_DEC:  res = a - 8'd1;
            OP_CLR:  res = '0;
            OP_CPL:  res = ~a;
            default: res = a;
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
// Accumulator ALU top: picks the unit result and flag updates per code, with
// an optional output register. Flags not named by a code pass through.
// Assumes the inputs are stable around the rising edge when REG_OUT=1.
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [BYTE_W-1:0] acc_i,
    input  logic [BYTE_W-1:0] opnd_i,
    input  logic              cy_i,
    input  logic              ac_i,
    output logic [BYTE_W-1:0] res_o,
    output logic [BYTE_W-1:0] opnd_o,
    output logic              cy_o,
    output logic              ac_o
);
    alu_op_e           op_e;
    logic              add_cin;
    logic [BYTE_W-1:0] sum, da_res, logic_res;
    logic              sum_cy, sum_ac, da_cy;
    logic [BYTE_W-1:0] rl, rlc, rr, rrc, swap, xchd_a, xchd_b;
    logic              rlc_cy, rrc_cy;
    logic [BYTE_W-1:0] nxt_res, nxt_opnd;
    logic              nxt_cy, nxt_ac;

    assign op_e    = alu_op_e'(op_i);
    assign add_cin = (op_e == OP_ADDC) ? cy_i : 1'b0;

    acc_alu_arith u_arith (
        .a(acc_i), .b(opnd_i), .add_cin(add_cin), .cy_in(cy_i), .ac_in(ac_i),
        .sum(sum), .sum_cy(sum_cy), .sum_ac(sum_ac), .da_res(da_res), .da_cy(da_cy)
    );

    acc_alu_shift u_shift (
        .a(acc_i), .b(opnd_i), .cin(cy_i),
        .rl(rl), .rlc(rlc), .rlc_cy(rlc_cy), .rr(rr), .rrc(rrc), .rrc_cy(rrc_cy),
        .swap(swap), .xchd_a(xchd_a), .xchd_b(xchd_b)
    );

    acc_alu_logic u_logic (
        .op(op_e), .a(acc_i), .b(opnd_i), .res(logic_res)
    );

    // Result and flag select; defaults hold the flags and operand
    always_comb begin
        nxt_res  = acc_i;
        nxt_opnd = opnd_i;
        nxt_cy   = cy_i;
        nxt_ac   = ac_i;
        case (op_e)
            OP_ADD, OP_ADDC: begin
                nxt_res = sum;
                nxt_cy  = sum_cy;
                nxt_ac  = sum_ac;
            end
            OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC, OP_CLR, OP_CPL:
                nxt_res = logic_res;
            OP_RL:   nxt_res = rl;
            OP_RR:   nxt_res = rr;
            OP_SWAP: nxt_res = swap;
            OP_RLC: begin
                nxt_res = rlc;
                nxt_cy  = rlc_cy;
            end
            OP_RRC: begin
                nxt_res = rrc;
                nxt_cy  = rrc_cy;
            end
            OP_DA: begin
                nxt_res = da_res;
                nxt_cy  = da_cy;
            end
            OP_XCHD: begin
                nxt_res  = xchd_a;
                nxt_opnd = xchd_b;
            end
            default: ;
        endcase
    end

    generate
        if (REG_OUT) begin : g_reg
            // Output stage with synchronous clear
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    res_o  <= '0;
                    opnd_o <= '0;
                    cy_o   <= 1'b0;
                    ac_o   <= 1'b0;
                end else begin
                    res_o  <= nxt_res;
                    opnd_o <= nxt_opnd;
                    cy_o   <= nxt_cy;
                    ac_o   <= nxt_ac;
                end
            end

            // R11
            reg_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (res_o == $past(nxt_res) && cy_o == $past(nxt_cy)
                                  && ac_o == $past(nxt_ac) && opnd_o == $past(nxt_opnd)));
        end else begin : g_comb
            assign res_o  = nxt_res;
            assign opnd_o = nxt_opnd;
            assign cy_o   = nxt_cy;
            assign ac_o   = nxt_ac;
        end
    endgenerate

    // R2
    add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_ADD) |-> ({nxt_cy, nxt_res} == ({1'b0, acc_i} + {1'b0, opnd_i})));

    // R9
    logic_flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e >= OP_AND && op_e <= OP_CPL) |-> (nxt_cy == cy_i && nxt_ac == ac_i));

    // R5
    da_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_DA && cy_i) |-> (nxt_cy && nxt_ac == ac_i));

    // R6
    rlc_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_RLC) |-> (nxt_cy == acc_i[BYTE_W-1] && nxt_res[0] == cy_i));

    // R7
    rot_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_RL || op_e == OP_RR || op_e == OP_SWAP)
        |-> ($countones(nxt_res) == $countones(acc_i) && nxt_cy == cy_i && nxt_ac == ac_i));

    // R8
    xchd_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_XCHD) |-> (nxt_res[BYTE_W-1:NIB_W] == acc_i[BYTE_W-1:NIB_W]
                               && nxt_opnd[BYTE_W-1:NIB_W] == opnd_i[BYTE_W-1:NIB_W]
                               && nxt_res[NIB_W-1:0] == opnd_i[NIB_W-1:0]));

    // R10
    opnd_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e != OP_XCHD) |-> (nxt_opnd == opnd_i));
endmodule

// File: tb/acc_alu_tb_top.sv
// Bench: behavioural integer model, one-cycle expectation queue, compared every clock.
module acc_alu_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = '0;
    logic [7:0] acc_i = '0, opnd_i = '0;
    logic       cy_i = 1'b0, ac_i = 1'b0;
    logic [7:0] res_o, opnd_o;
    logic       cy_o, ac_o;

    int checks = 0;
    int fails  = 0;
    logic [17:0] exp_q[$];
    int          op_q[$];

    always #2 clk = ~clk;

    acc_alu dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
        .cy_i(cy_i), .ac_i(ac_i), .res_o(res_o), .opnd_o(opnd_o), .cy_o(cy_o), .ac_o(ac_o)
    );

    function automatic logic [17:0] model(int op, int a, int b, int c, int ac);
        int r = a, co = c, aco = ac, ob = b, cin, s, t, c1;
        case (op)
            0, 1: begin
                cin = (op == 1) ? c : 0;
                s   = a + b + cin;
                r   = s % 256;
                co  = (s > 255) ? 1 : 0;
                aco = ((a % 16) + (b % 16) + cin > 15) ? 1 : 0;
            end
            2: r = a & b;
            3: r = a | b;
            4: r = a ^ b;
            5: r = (a + 1) % 256;
            6: r = (a + 255) % 256;
            7: r = 0;
            8: r = 255 - a;
            9: r = (a * 2) % 256 + a / 128;
            10: begin r = (a * 2) % 256 + c; co = a / 128; end
            11: r = a / 2 + (a % 2) * 128;
            12: begin r = a / 2 + c * 128; co = a % 2; end
            13: r = (a % 16) * 16 + a / 16;
            14: begin
                t = a;
                if (ac == 1 || (t % 16) > 9) t = t + 6;
                c1 = (c == 1 || t > 255) ? 1 : 0;
                t = t % 256;
                if (c1 == 1 || t > 153) t = t + 96;
                co = (c1 == 1 || t > 255) ? 1 : 0;
                r = t % 256;
            end
            default: begin
                r  = (a / 16) * 16 + b % 16;
                ob = (b / 16) * 16 + a % 16;
            end
        endcase
        return {r[7:0], co[0], aco[0], ob[7:0]};
    endfunction

    function automatic string req_of(int op);
        case (op)
            0, 1:  return "R2/R3";
            14:    return "R4/R5";
            10, 12: return "R6";
            9, 11, 13: return "R7";
            15:    return "R8";
            default: return "R9/R10";
        endcase
    endfunction

    task automatic compare_front();
        logic [17:0] e;
        int op;
        e  = exp_q.pop_front();
        op = op_q.pop_front();
        checks++;
        if ({res_o, cy_o, ac_o, opnd_o} !== e) begin
            fails++;
            $display("FAIL %s/R11 op=%0d actual res=%h cy=%b ac=%b opnd=%h expected res=%h cy=%b ac=%b opnd=%h",
                     req_of(op), op, res_o, cy_o, ac_o, opnd_o, e[17:10], e[9], e[8], e[7:0]);
        end
    endtask

    task automatic step(int op, int a, int b, int c, int ac);
        @(negedge clk);
        if (exp_q.size() > 0) compare_front();
        op_i = op[3:0]; acc_i = a[7:0]; opnd_i = b[7:0]; cy_i = c[0]; ac_i = ac[0];
        exp_q.push_back(model(op, a, b, c, ac));
        op_q.push_back(op);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        op_i = 4'd0; acc_i = 8'hFF; opnd_i = 8'h77; cy_i = 1'b1; ac_i = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if ({res_o, cy_o, ac_o, opnd_o} !== 18'd0) begin
            fails++;
            $display("FAIL R1 actual res=%h cy=%b ac=%b opnd=%h expected all zero",
                     res_o, cy_o, ac_o, opnd_o);
        end
        rst_n = 1'b1;
        exp_q.push_back(model(0, 255, 119, 1, 1));
        op_q.push_back(0);
        // R2/R3 add corners
        step(0, 8'hFF, 8'h01, 0, 0);
        step(1, 8'hFF, 8'h00, 1, 0);   // carry only from carry-in
        step(1, 8'h0F, 8'h00, 1, 0);   // aux carry only from carry-in
        step(0, 8'h08, 8'h08, 1, 0);   // plain add ignores cy_i
        // R4/R5 decimal adjust corners
        step(14, 8'h9A, 8'h00, 0, 0);
        step(14, 8'h15, 8'h00, 0, 1);
        step(14, 8'h34, 8'h00, 1, 0);  // sticky carry
        step(14, 8'hFB, 8'h00, 0, 0);  // first step overflows
        step(14, 8'h99, 8'h00, 0, 1);
        // R6 rotates through carry
        step(10, 8'h80, 8'h00, 0, 1);
        step(12, 8'h01, 8'h00, 0, 0);
        step(12, 8'h00, 8'h00, 1, 1);
        // R7/R8/R9
        step(9, 8'h81, 8'h00, 1, 1);
        step(13, 8'hA5, 8'h00, 0, 1);
        step(15, 8'h12, 8'h34, 1, 0);
        step(5, 8'hFF, 8'h00, 0, 1);
        step(6, 8'h00, 8'h00, 1, 0);
        step(8, 8'h3C, 8'h99, 1, 1);
        // random mix across all codes
        for (int i = 0; i < 600; i++)
            step($urandom_range(0, 15), $urandom_range(0, 255), $urandom_range(0, 255),
                 $urandom_range(0, 1), $urandom_range(0, 1));
        @(negedge clk);
        if (exp_q.size() > 0) compare_front();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule